// File: doc/BRIEF.md
# Multicycle 16-bit Load/Store Processor Core

This block is a small multicycle processor core for a 16-bit educational load/store instruction set. It holds eight 16-bit general registers, a program counter and a three-bit one-hot condition-code register. Each instruction is fetched as one word over a single memory request port. The PC is bumped as soon as the word arrives, and the top four bits of the word select the operation. The core runs register arithmetic and logic, loads and stores with PC-relative, base-plus-offset and pointer-indirect addressing, conditional branches, jumps, subroutine calls, and a trap that vectors through a table in low memory.

All memory traffic uses one valid/ready request channel and one read-response channel, so a slow memory or a memory-mapped device can stall the core at any point. A request is presented with `mem_req_valid` high and is held unchanged until the cycle in which `mem_req_ready` is high; that cycle is the handshake. Only one request is ever outstanding. A read handshake is followed, one or more cycles later, by exactly one `mem_rsp_valid` pulse carrying the data. A write is complete at its handshake and gets no response. When the core decodes an opcode that it does not implement, it raises an error output and stops issuing requests.

Top module: `edu16_core`

## Requirements
- R1: On reset all registers are zero, the condition code is z (3'b010), and the first request is a read of address `RESET_PC` with `illegal_op` low.
- R2: A request keeps valid, address, write flag and write data unchanged while ready is low. Only one request is outstanding at a time. Read data is taken only on a `mem_rsp_valid` pulse after the read handshake.
- R3: The PC is incremented when the fetched word arrives, before execution. Opcodes LD=2, ST=3 and LEA=14 use PC + sign-extended bits 8:0. LDR=6 and STR=7 use R[bits 8:6] + sign-extended bits 5:0. Bits 11:9 name the destination or store source.
- R4: ADD=1 and AND=5 take R[bits 8:6] and, as second operand, either the sign-extended bits 4:0 when bit 5 is 1 or R[bits 2:0] when bit 5 is 0. NOT=9 writes the inverse of R[bits 8:6]. All arithmetic wraps modulo 2^16.
- R5: The condition code is one-hot {n,z,p}: n when result bit 15 is 1, z when the result is zero, p otherwise. ADD, AND, NOT, LD, LDR, LDI and LEA write it from their result. No other instruction changes it.
- R6: BR=0 is taken when (bits 11:9 AND condition code) is nonzero, and then loads PC + sign-extended bits 8:0. A mask of 000 is never taken.
- R7: LDI=10 reads a pointer at PC + sign-extended bits 8:0, then reads the data at that pointer. STI=11 reads the same pointer, then writes R[bits 11:9] to it.
- R8: JMP=12 loads the PC from R[bits 8:6]. JSR=4 saves the incremented PC in R7 and jumps to PC + sign-extended bits 10:0 when bit 11 is 1, or else to R[bits 8:6] as read before R7 is written.
- R9: TRAP=15 saves the incremented PC in R7, reads the word at the zero-extended bits 7:0, and loads it into the PC.
- R10: Opcodes 8 and 13 raise `illegal_op`, which then stays high, and no further memory request is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 16 | Word address of the request |
| mem_req_wdata | output | 16 | Write data |
| mem_rsp_valid | input | 1 | One-cycle pulse carrying read data |
| mem_rsp_data | input | 16 | Read data |
| illegal_op | output | 1 | Unimplemented opcode seen; core halted |

## Verification
The fetch request appears in the cycle after the previous instruction finishes. Execution follows one cycle after the fetch response. A register or PC result is visible one cycle later, so an ALU, branch or jump instruction takes three cycles plus any stall cycles. A load adds a request and a wait, an indirect access adds two such pairs, and a store adds one request. Because every result shows up through the order and contents of later memory requests, the bench samples on the falling edge and compares each handshaken request, in order, with a behavioural instruction-level model driven by randomized ready and response delays. It also checks request hold under back-pressure, the quiet state after an illegal opcode, and the final memory image.

// File: rtl/edu16_pkg.sv
package edu16_pkg;
  localparam int XLEN = 16;
  localparam int NREG = 8;
  localparam int LINK_REG = 7;

  typedef enum logic [3:0] {
    OP_BR    = 4'd0,  OP_ADD  = 4'd1,  OP_LD   = 4'd2,  OP_ST   = 4'd3,
    OP_JSR   = 4'd4,  OP_AND  = 4'd5,  OP_LDR  = 4'd6,  OP_STR  = 4'd7,
    OP_RSV8  = 4'd8,  OP_NOT  = 4'd9,  OP_LDI  = 4'd10, OP_STI  = 4'd11,
    OP_JMP   = 4'd12, OP_RSV13 = 4'd13, OP_LEA = 4'd14, OP_TRAP = 4'd15
  } opcode_e;

  typedef enum logic [2:0] {
    ST_FETCH, ST_FWAIT, ST_EXEC, ST_RREQ, ST_RWAIT, ST_WREQ, ST_HALT
  } state_e;

  typedef enum logic [1:0] {ALU_ADD, ALU_AND, ALU_NOT, ALU_PASS} alu_op_e;

  // one-hot {n,z,p} of a result word
  function automatic logic [2:0] flags_of(input logic [XLEN-1:0] v);
    if (v[XLEN-1])      return 3'b100;
    else if (v == '0)   return 3'b010;
    else                return 3'b001;
  endfunction
endpackage

// File: rtl/edu16_regfile.sv
module edu16_regfile #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr_a,
  output logic [WIDTH-1:0] rdata_a,
  input  logic [AW-1:0]    raddr_b,
  output logic [WIDTH-1:0] rdata_b,
  input  logic [AW-1:0]    raddr_c,
  output logic [WIDTH-1:0] rdata_c
);
  logic [WIDTH-1:0] regs [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
    end else if (we) begin
      regs[waddr] <= wdata;
    end
  end

  assign rdata_a = regs[raddr_a];
  assign rdata_b = regs[raddr_b];
  assign rdata_c = regs[raddr_c];
endmodule

// File: rtl/edu16_alu.sv
module edu16_alu
  import edu16_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  alu_op_e          op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] y
);
  always_comb begin
    unique case (op)
      ALU_ADD: y = a + b;
      ALU_AND: y = a & b;
      ALU_NOT: y = ~a;
      default: y = b;
    endcase
  end
endmodule

// File: rtl/edu16_agen.sv
module edu16_agen #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] pc,
  input  logic [WIDTH-1:0] base,
  input  logic [WIDTH-1:0] ir,
  output logic [WIDTH-1:0] pc_rel9,
  output logic [WIDTH-1:0] pc_rel11,
  output logic [WIDTH-1:0] base_rel6,
  output logic [WIDTH-1:0] vec_addr
);
  localparam int W9  = 9;
  localparam int W11 = 11;
  localparam int W6  = 6;
  localparam int WV  = 8;

  logic [WIDTH-1:0] off9, off11, off6;

  assign off9  = {{(WIDTH-W9){ir[W9-1]}},   ir[W9-1:0]};
  assign off11 = {{(WIDTH-W11){ir[W11-1]}}, ir[W11-1:0]};
  assign off6  = {{(WIDTH-W6){ir[W6-1]}},   ir[W6-1:0]};

  assign pc_rel9   = pc + off9;
  assign pc_rel11  = pc + off11;
  assign base_rel6 = base + off6;
  assign vec_addr  = {{(WIDTH-WV){1'b0}}, ir[WV-1:0]};
endmodule

// File: rtl/edu16_core.sv
module edu16_core
  import edu16_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_PC = 16'h0100
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic            mem_req_write,
  output logic [XLEN-1:0] mem_req_addr,
  output logic [XLEN-1:0] mem_req_wdata,
  input  logic            mem_rsp_valid,
  input  logic [XLEN-1:0] mem_rsp_data,
  output logic            illegal_op
);
  localparam int RAW = $clog2(NREG);
  localparam int IMMW = 5;

  state_e            state;
  logic [XLEN-1:0]   pc, ir, mar;
  logic [2:0]        cc;
  logic              ind_pend;
  logic              illegal_q;
  opcode_e           op;
  logic [RAW-1:0]    f_dst, f_base, f_src2;

  logic [XLEN-1:0]   rd_base, rd_src2, rd_dst;
  logic              rf_we, cc_we;
  logic [RAW-1:0]    rf_waddr;
  logic [XLEN-1:0]   rf_wdata;

  alu_op_e           alu_op;
  logic [XLEN-1:0]   alu_b, alu_y;
  logic [XLEN-1:0]   pc_rel9, pc_rel11, base_rel6, vec_addr;
  logic              br_hit;

  assign op     = opcode_e'(ir[XLEN-1 -: 4]);
  assign f_dst  = ir[11:9];
  assign f_base = ir[8:6];
  assign f_src2 = ir[2:0];
  assign br_hit = (ir[11:9] & cc) != 3'b000;

  edu16_regfile #(.WIDTH(XLEN), .DEPTH(NREG)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .we(rf_we), .waddr(rf_waddr), .wdata(rf_wdata),
    .raddr_a(f_base), .rdata_a(rd_base),
    .raddr_b(f_src2), .rdata_b(rd_src2),
    .raddr_c(f_dst),  .rdata_c(rd_dst)
  );

  always_comb begin
    unique case (op)
      OP_ADD:  alu_op = ALU_ADD;
      OP_AND:  alu_op = ALU_AND;
      OP_NOT:  alu_op = ALU_NOT;
      default: alu_op = ALU_PASS;
    endcase
  end

  assign alu_b = ir[5] ? {{(XLEN-IMMW){ir[IMMW-1]}}, ir[IMMW-1:0]} : rd_src2;

  edu16_alu #(.WIDTH(XLEN)) u_alu (
    .op(alu_op), .a(rd_base), .b(alu_b), .y(alu_y)
  );

  edu16_agen #(.WIDTH(XLEN)) u_agen (
    .pc(pc), .base(rd_base), .ir(ir),
    .pc_rel9(pc_rel9), .pc_rel11(pc_rel11),
    .base_rel6(base_rel6), .vec_addr(vec_addr)
  );

  // register write-back and condition-code update
  always_comb begin
    rf_we    = 1'b0;
    cc_we    = 1'b0;
    rf_waddr = f_dst;
    rf_wdata = alu_y;
    if (state == ST_EXEC) begin
      unique case (op)
        OP_ADD, OP_AND, OP_NOT: begin
          rf_we = 1'b1;
          cc_we = 1'b1;
        end
        OP_LEA: begin
          rf_we    = 1'b1;
          cc_we    = 1'b1;
          rf_wdata = pc_rel9;
        end
        OP_JSR, OP_TRAP: begin
          rf_we    = 1'b1;
          rf_waddr = RAW'(LINK_REG);
          rf_wdata = pc;
        end
        default: ;
      endcase
    end else if (state == ST_RWAIT && mem_rsp_valid && !ind_pend && op != OP_TRAP) begin
      rf_we    = 1'b1;
      cc_we    = 1'b1;
      rf_wdata = mem_rsp_data;
    end
  end

  // sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_FETCH;
      pc        <= RESET_PC;
      ir        <= '0;
      mar       <= '0;
      cc        <= 3'b010;
      ind_pend  <= 1'b0;
      illegal_q <= 1'b0;
    end else begin
      if (cc_we) cc <= flags_of(rf_wdata);
      unique case (state)
        ST_FETCH: if (mem_req_ready) state <= ST_FWAIT;
        ST_FWAIT: begin
          if (mem_rsp_valid) begin
            ir    <= mem_rsp_data;
            pc    <= pc + XLEN'(1);
            state <= ST_EXEC;
          end
        end
        ST_EXEC: begin
          state <= ST_FETCH;
          unique case (op)
            OP_ADD, OP_AND, OP_NOT, OP_LEA: ;
            OP_BR:  if (br_hit) pc <= pc_rel9;
            OP_JMP: pc <= rd_base;
            OP_JSR: pc <= ir[11] ? pc_rel11 : rd_base;
            OP_LD: begin
              mar   <= pc_rel9;
              state <= ST_RREQ;
            end
            OP_LDI, OP_STI: begin
              mar      <= pc_rel9;
              ind_pend <= 1'b1;
              state    <= ST_RREQ;
            end
            OP_LDR: begin
              mar   <= base_rel6;
              state <= ST_RREQ;
            end
            OP_ST: begin
              mar   <= pc_rel9;
              state <= ST_WREQ;
            end
            OP_STR: begin
              mar   <= base_rel6;
              state <= ST_WREQ;
            end
            OP_TRAP: begin
              mar   <= vec_addr;
              state <= ST_RREQ;
            end
            default: begin
              illegal_q <= 1'b1;
              state     <= ST_HALT;
            end
          endcase
        end
        ST_RREQ: if (mem_req_ready) state <= ST_RWAIT;
        ST_RWAIT: begin
          if (mem_rsp_valid) begin
            if (ind_pend) begin
              mar      <= mem_rsp_data;
              ind_pend <= 1'b0;
              state    <= (op == OP_STI) ? ST_WREQ : ST_RREQ;
            end else begin
              if (op == OP_TRAP) pc <= mem_rsp_data;
              state <= ST_FETCH;
            end
          end
        end
        ST_WREQ: if (mem_req_ready) state <= ST_FETCH;
        default: state <= ST_HALT;
      endcase
    end
  end

  assign mem_req_valid = (state == ST_FETCH) || (state == ST_RREQ) || (state == ST_WREQ);
  assign mem_req_write = (state == ST_WREQ);
  assign mem_req_addr  = (state == ST_FETCH) ? pc : mar;
  assign mem_req_wdata = rd_dst;
  assign illegal_op    = illegal_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_write) && $stable(mem_req_wdata))); // R2

  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FWAIT && mem_rsp_valid) |=> (pc == $past(pc) + XLEN'(1))); // R3

  AST_CC_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cc) == 1); // R5

  AST_CC_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_EXEC && (op == OP_ST || op == OP_STR || op == OP_BR || op == OP_JMP
      || op == OP_JSR)) |=> $stable(cc)); // R5

  AST_BR_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_EXEC && op == OP_BR && !br_hit) |=> (pc == $past(pc))); // R6

  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_op |=> (illegal_op && !mem_req_valid)); // R10
endmodule

// File: tb/edu16_core_bench.sv
`timescale 1ns/1ps
module edu16_core_bench;
  localparam logic [15:0] START = 16'h0100;
  localparam int MEMW = 1024;
  localparam int WDOG = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mem_req_valid, mem_req_write;
  logic        mem_req_ready = 1'b0;
  logic [15:0] mem_req_addr, mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [15:0] mem_rsp_data = '0;
  logic        illegal_op;

  edu16_core #(.RESET_PC(START)) u_edu16_core (
    .clk(clk), .rst_n(rst_n),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .illegal_op(illegal_op)
  );

  always #2 clk = ~clk;

  logic [15:0] dmem [MEMW];
  logic [15:0] refm [MEMW];
  logic [15:0] rreg [8];
  logic [15:0] rpc;
  logic [2:0]  rcc;
  bit          rhalt;
  string       next_tag;
  logic [32:0] expq [$];
  string       tagq [$];
  int nchk = 0, nfail = 0;

  function automatic int ix(input logic [15:0] a);
    return int'(a[9:0]);
  endfunction

  function automatic logic [15:0] sx(input logic [15:0] w, input int bits);
    logic signed [15:0] t;
    t = signed'(w << (16 - bits));
    return 16'(t >>> (16 - bits));
  endfunction

  function automatic logic [2:0] nzp(input logic [15:0] v);
    if (v[15]) return 3'b100;
    if (v == 16'h0) return 3'b010;
    return 3'b001;
  endfunction

  task automatic check(input bit ok, input string tag, input string act, input string exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %s expected %s", tag, act, exp);
    end
  endtask

  task automatic push(input bit wr, input logic [15:0] a, input logic [15:0] d, input string t);
    expq.push_back({wr, a, wr ? d : 16'h0});
    tagq.push_back(t);
  endtask

  task automatic setr(input int r, input logic [15:0] v);
    rreg[r] = v;
    rcc = nzp(v);
  endtask

  // instruction-level reference model: one instruction per call
  task automatic ref_step();
    logic [15:0] w, ea, p, tgt, opb;
    int d, b;
    w = refm[ix(rpc)];
    push(1'b0, rpc, 16'h0, next_tag);
    rpc = rpc + 16'd1;
    d = int'(w[11:9]);
    b = int'(w[8:6]);
    next_tag = "R3";
    opb = w[5] ? sx(w, 5) : rreg[int'(w[2:0])];
    case (int'(w[15:12]))
      0: begin
        next_tag = "R6,R5";
        if ((w[11:9] & rcc) != 3'b000) rpc = rpc + sx(w, 9);
      end
      1: setr(d, rreg[b] + opb);
      5: setr(d, rreg[b] & opb);
      9: setr(d, ~rreg[b]);
      14: setr(d, rpc + sx(w, 9));
      2: begin ea = rpc + sx(w, 9); push(1'b0, ea, 16'h0, "R3"); setr(d, refm[ix(ea)]); end
      6: begin ea = rreg[b] + sx(w, 6); push(1'b0, ea, 16'h0, "R3"); setr(d, refm[ix(ea)]); end
      10: begin
        ea = rpc + sx(w, 9); push(1'b0, ea, 16'h0, "R7");
        p = refm[ix(ea)];    push(1'b0, p, 16'h0, "R7");
        setr(d, refm[ix(p)]);
      end
      3: begin ea = rpc + sx(w, 9); push(1'b1, ea, rreg[d], "R3"); refm[ix(ea)] = rreg[d]; end
      7: begin ea = rreg[b] + sx(w, 6); push(1'b1, ea, rreg[d], "R3"); refm[ix(ea)] = rreg[d]; end
      11: begin
        ea = rpc + sx(w, 9); push(1'b0, ea, 16'h0, "R7");
        p = refm[ix(ea)];    push(1'b1, p, rreg[d], "R7");
        refm[ix(p)] = rreg[d];
      end
      12: begin rpc = rreg[b]; next_tag = "R8"; end
      4: begin
        tgt = w[11] ? rpc + sx(w, 11) : rreg[b];
        rreg[7] = rpc; rpc = tgt; next_tag = "R8";
      end
      15: begin
        rreg[7] = rpc; ea = {8'h00, w[7:0]};
        push(1'b0, ea, 16'h0, "R9");
        rpc = refm[ix(ea)]; next_tag = "R9";
      end
      default: rhalt = 1'b1;
    endcase
  endtask

  // encoders
  function automatic logic [15:0] enc(input int op, input int d, input int b, input int low);
    return {4'(op), 3'(d), 3'(b), 6'(low)};
  endfunction
  function automatic logic [15:0] enc9(input int op, input int d, input int off);
    return {4'(op), 3'(d), 9'(off)};
  endfunction
  function automatic logic [15:0] addi(input int d, input int b, input int imm);
    return enc(1, d, b, 32 | (imm & 31));
  endfunction
  function automatic logic [15:0] andi(input int d, input int b, input int imm);
    return enc(5, d, b, 32 | (imm & 31));
  endfunction

  task automatic put(input int a, input logic [15:0] w);
    dmem[a] = w;
    refm[a] = w;
  endtask

  task automatic clear_mem();
    for (int i = 0; i < MEMW; i++) begin dmem[i] = '0; refm[i] = '0; end
  endtask

  task automatic load_prog1();
    clear_mem();
    put('h100, andi(0, 0, 0));
    put('h101, addi(1, 0, -1));
    put('h102, addi(2, 0, 15));
    put('h103, enc(1, 3, 1, 2));          // ADD reg form
    put('h104, enc(9, 4, 3, 63));         // NOT
    put('h105, enc(5, 5, 4, 2));          // AND reg form
    put('h106, enc9(2, 6, 'h79));         // LD
    put('h107, enc9(14, 0, 'h88));        // LEA
    put('h108, enc(6, 1, 0, -2));         // LDR
    put('h109, enc(7, 3, 0, 5));          // STR
    put('h10A, enc9(10, 2, 'h76));        // LDI
    put('h10B, enc9(11, 4, 'h76));        // STI
    put('h10C, enc9(0, 2, 2));            // BRz (not taken)
    put('h10D, enc9(0, 4, 1));            // BRn (taken)
    put('h10E, 16'h8000);
    put('h10F, addi(5, 5, 0));
    put('h110, enc9(0, 0, 1));            // mask 000
    put('h111, enc9(0, 7, 1));            // always
    put('h112, 16'hD000);
    put('h113, {4'd4, 1'b1, 11'h2C});     // JSR offset
    put('h114, enc9(14, 6, 'h3B));        // LEA R6
    put('h115, enc(4, 0, 6, 0));          // JSR via R6
    put('h116, {8'hF0, 8'h20});           // TRAP x20
    put('h117, enc(4, 0, 7, 0));          // JSR via R7 itself
    put('h118, enc9(3, 7, 'h6D));
    put('h119, andi(1, 1, 0));
    put('h11A, addi(1, 1, 3));
    put('h11B, addi(1, 1, -1));
    put('h11C, enc9(0, 1, -2));           // BRp loop
    put('h11D, enc9(3, 1, 'h69));
    put('h11E, enc9(3, 2, 'h69));
    put('h11F, enc9(3, 5, 'h69));
    put('h120, 16'h8000);
    put('h140, enc9(3, 7, 'h42));
    put('h141, enc(12, 0, 7, 0));
    put('h150, enc9(3, 7, 'h33));
    put('h151, enc(12, 0, 7, 0));
    put('h160, enc9(3, 7, 'h24));
    put('h161, enc(12, 0, 7, 0));
    put('h020, 16'h0160);
    put('h180, 16'h1234);
    put('h181, 16'h01A0);
    put('h182, 16'h01A1);
    put('h18E, 16'h7FFF);
    put('h1A0, 16'h8005);
  endtask

  task automatic load_prog2();
    clear_mem();
    put('h100, andi(0, 0, 0));
    put('h101, enc9(2, 1, 'h7E));         // LD 0x7FFF
    put('h102, addi(1, 1, 1));            // wraps to 0x8000
    put('h103, enc9(0, 4, 1));
    put('h104, 16'h8000);
    put('h105, addi(2, 0, -16));
    put('h106, enc9(14, 3, -6));          // LEA negative
    put('h107, enc(7, 2, 3, -32));
    put('h108, enc(7, 1, 3, 31));
    put('h109, {8'hF0, 8'hFF});           // TRAP xFF
    put('h10A, enc(1, 4, 1, 1));          // 0x8000+0x8000 = 0
    put('h10B, enc9(0, 2, 1));
    put('h10C, 16'h8000);
    put('h10D, enc(6, 5, 3, 0));
    put('h10E, enc9(3, 5, 'h73));
    put('h10F, 16'hD000);
    put('h170, enc9(3, 7, 'h10));
    put('h171, enc(12, 0, 7, 0));
    put('h0FF, 16'h0170);
    put('h180, 16'h7FFF);
  endtask

  task automatic run_prog(input int which);
    int cyc, pend_d, mism;
    bit pend, hold, done, rdy;
    logic [15:0] pend_a, h_addr, h_wdata;
    logic h_wr;
    logic [32:0] act, ex;
    string t;
    rst_n = 1'b0; mem_req_ready = 1'b0; mem_rsp_valid = 1'b0;
    if (which == 1) load_prog1(); else load_prog2();
    for (int i = 0; i < 8; i++) rreg[i] = '0;
    rpc = START; rcc = 3'b010; rhalt = 1'b0; next_tag = "R1";
    expq.delete(); tagq.delete();
    pend = 0; hold = 0; done = 0; cyc = 0; pend_d = 0;
    pend_a = '0; h_addr = '0; h_wdata = '0; h_wr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(mem_req_valid && !mem_req_write && mem_req_addr == START && !illegal_op, "R1",
          $sformatf("v=%0d w=%0d a=%h ill=%0d", mem_req_valid, mem_req_write, mem_req_addr, illegal_op),
          $sformatf("v=1 w=0 a=%h ill=0", START));
    while (!done) begin
      if (cyc != 0) @(negedge clk);
      cyc++;
      mem_rsp_valid = 1'b0;
      if (pend) begin
        if (pend_d == 0) begin
          mem_rsp_valid = 1'b1; mem_rsp_data = dmem[ix(pend_a)]; pend = 0;
        end else pend_d--;
      end
      if (hold) begin
        check(mem_req_valid && mem_req_addr == h_addr && mem_req_write == h_wr
              && mem_req_wdata == h_wdata, "R2",
              $sformatf("v=%0d a=%h w=%0d d=%h", mem_req_valid, mem_req_addr, mem_req_write, mem_req_wdata),
              $sformatf("v=1 a=%h w=%0d d=%h", h_addr, h_wr, h_wdata));
        hold = 0;
      end
      if (illegal_op) begin
        check(rhalt && expq.size() == 0, "R10",
              $sformatf("halt_model=%0d pending=%0d", rhalt, expq.size()), "halt_model=1 pending=0");
        mism = 0;
        repeat (8) begin
          @(negedge clk);
          if (mem_req_valid || !illegal_op) mism++;
        end
        check(mism == 0, "R10", $sformatf("%0d noisy cycles", mism), "0 noisy cycles");
        done = 1;
      end else begin
        if (expq.size() == 0 && !rhalt) ref_step();
        rdy = ($urandom_range(0, 3) != 0);
        mem_req_ready = rdy;
        if (mem_req_valid && rdy) begin
          act = {mem_req_write, mem_req_addr, mem_req_write ? mem_req_wdata : 16'h0};
          if (expq.size() == 0) begin
            check(1'b0, "R2", $sformatf("%h", act), "no request");
          end else begin
            ex = expq.pop_front(); t = tagq.pop_front();
            check(act == ex, t, $sformatf("w=%0d a=%h d=%h", act[32], act[31:16], act[15:0]),
                  $sformatf("w=%0d a=%h d=%h", ex[32], ex[31:16], ex[15:0]));
          end
          if (mem_req_write) dmem[ix(mem_req_addr)] = mem_req_wdata;
          else begin
            pend = 1; pend_a = mem_req_addr; pend_d = $urandom_range(0, 2);
          end
        end else if (mem_req_valid) begin
          hold = 1; h_addr = mem_req_addr; h_wr = mem_req_write; h_wdata = mem_req_wdata;
        end
      end
      if (cyc > WDOG && !done) begin
        check(1'b0, "R10", "watchdog expired", "halt");
        done = 1;
      end
    end
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mism = 0;
    for (int i = 0; i < MEMW; i++) if (dmem[i] !== refm[i]) mism++;
    check(mism == 0, "R4", $sformatf("%0d differing words", mism), "0 differing words");
  endtask

  initial begin
    run_prog(1);
    run_prog(2);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule